// File: doc/BRIEF.md
# Dual-Lane Saturating 16x16 Multiplier

This block multiplies two 16-bit operands and produces a saturated result that goes straight into a register file. There are two multiplier lanes. The destination picks the lane, so the caller gives no explicit lane select.

- For a 32-bit result, the parity of the destination register index picks the lane.
- For a 16-bit result, the half of the destination register picks the lane, and only that half is written.

Four arithmetic modes set how the operands are read and how the product is scaled. A mixed-sign option can be added on top of any mode. The block keeps no accumulator and has no path to write one: every product lands in the destination and nothing else.

Each operation is registered once. A valid request produces, one clock later, a write strobe with the register index, a two-bit half mask and the write data. An illegal request instead produces a single error pulse and no write.

Top module: `dual_mul16_sat`

## Requirements
- R1: For a 32-bit result (`wide`=1), an even `dst_idx` uses lane 0 and an odd one uses lane 1. `hi_half` is ignored. The write carries `wr_idx`=`dst_idx` and `wr_mask`=2'b11.
- R2: For a 16-bit result, `hi_half`=0 uses lane 0 and writes `wr_mask`=2'b01 with the value in `wr_data[15:0]`. `hi_half`=1 uses lane 1 and writes `wr_mask`=2'b10 with the value in `wr_data[31:16]`. The half that is not written reads zero.
- R3: The mixed-sign option (`mixed`=1) is legal only on lane 1. On lane 0 the block raises `err` for one cycle, with `wr_en`=0, `wr_mask`=0 and `wr_data`=0.
- R4: Mode 0 (signed fraction) reads both operands as signed 1.15 values and doubles the product. -1 x -1 saturates to 0x7FFFFFFF for a 32-bit result and to 0x7FFF for a 16-bit result.
- R5: Mode 2 (signed integer) gives the unshifted signed product, saturated to the signed range of the destination width.
- R6: Mode 3 (scaled signed integer) doubles the signed integer product before saturating it to the signed range.
- R7: Mode 1 (unsigned fraction) reads both operands as unsigned, does not shift, and clamps into the unsigned range of the destination width (0 up to all ones).
- R8: With `mixed`=1, `opa` is signed and `opb` is unsigned, and the result is saturated as signed. The doubling of the selected mode is kept: modes 0 and 3 double, modes 1 and 2 do not.
- R9: In the fractional modes (0 and 1) a 16-bit result is the upper half of the 32-bit scaled value after adding 0x8000, so ties round upward. It is then saturated to 16 bits. In the integer modes (2 and 3) the full product is saturated to 16 bits with no rounding.
- R10: Outputs change one clock after `in_valid`. A cycle without `in_valid` produces `wr_en`=0, `err`=0, `wr_mask`=0 and `wr_data`=0 on the next cycle, whatever the other inputs are.
- R11: A synchronous active-high `rst` clears every output to zero. This includes a request presented in the same cycle as the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| opa | input | 16 | First operand (signed in mixed mode) |
| opb | input | 16 | Second operand (unsigned in mixed mode) |
| dst_idx | input | 3 | Destination register index |
| wide | input | 1 | 1 = 32-bit result, 0 = 16-bit result |
| hi_half | input | 1 | For 16-bit results: 1 = upper half, 0 = lower half |
| mode | input | 2 | 0 signed fraction, 1 unsigned fraction, 2 signed integer, 3 scaled signed integer |
| mixed | input | 1 | Mixed-sign option |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 3 | Register index to write |
| wr_mask | output | 2 | Half mask: bit 0 = bits [15:0], bit 1 = bits [31:16] |
| wr_data | output | 32 | Write data, already placed in the selected half |
| err | output | 1 | Illegal combination, write suppressed |

## Verification
A wrong lane decision shows up at the ports on the very next cycle. It appears either as a mask on the wrong half, or as an error pulse where a write was expected (or a write where an error was expected). A bad signedness or scaling choice shows up as a wrong `wr_data` in that same cycle. The saturation corner cases only reveal such a fault at the extremes of the operand range, so the vectors pair extreme operands with every mode and both result widths. Because the block holds no state beyond its output register, every fault becomes visible exactly one cycle after the request that exposes it.

// File: rtl/dm16_pkg.sv
package dm16_pkg;

  typedef enum logic [1:0] {
    MD_FRAC_S     = 2'd0,
    MD_FRAC_U     = 2'd1,
    MD_INT_S      = 2'd2,
    MD_INT_SCALED = 2'd3
  } mul_mode_e;

  localparam int unsigned LANE_COUNT = 2;

endpackage

// File: rtl/dm16_lane_route.sv
module dm16_lane_route #(
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             wide,
  input  logic             hi_half,
  input  logic             mixed,
  output logic             lane,
  output logic [1:0]       mask,
  output logic             illegal
);

  always_comb begin
    if (wide) begin
      lane = dst_idx[0];
      mask = 2'b11;
    end else begin
      lane = hi_half;
      mask = hi_half ? 2'b10 : 2'b01;
    end
    illegal = mixed && !lane;
  end

endmodule

// File: rtl/dm16_mult_core.sv
module dm16_mult_core
  import dm16_pkg::*;
#(
  parameter int unsigned OP_W = 16,
  parameter int unsigned LANE = 0,
  localparam int unsigned EW  = OP_W + 1,
  localparam int unsigned PW  = 2 * EW,
  localparam int unsigned VW  = PW + 1
) (
  input  logic [OP_W-1:0]        opa,
  input  logic [OP_W-1:0]        opb,
  input  mul_mode_e              mode,
  input  logic                   mixed,
  output logic signed [VW-1:0]   scaled,
  output logic                   res_unsigned,
  output logic                   frac_round
);

  logic mixed_ok;

  // Only the upper lane implements the mixed-sign operand reading.
  generate
    if (LANE == 1) begin : g_mixed
      assign mixed_ok = mixed;
    end else begin : g_plain
      logic unused_mixed;
      assign unused_mixed = mixed;
      assign mixed_ok     = 1'b0;
    end
  endgenerate

  logic                 a_signed, b_signed, dbl;
  logic signed [EW-1:0] sa, sb;
  logic signed [PW-1:0] ax, bx, prod;

  always_comb begin
    a_signed     = (mode != MD_FRAC_U) || mixed_ok;
    b_signed     = (mode != MD_FRAC_U) && !mixed_ok;
    dbl          = (mode == MD_FRAC_S) || (mode == MD_INT_SCALED);
    res_unsigned = (mode == MD_FRAC_U) && !mixed_ok;
    frac_round   = (mode == MD_FRAC_S) || (mode == MD_FRAC_U);

    sa   = a_signed ? $signed({opa[OP_W-1], opa}) : $signed({1'b0, opa});
    sb   = b_signed ? $signed({opb[OP_W-1], opb}) : $signed({1'b0, opb});
    ax   = PW'(sa);
    bx   = PW'(sb);
    prod = ax * bx;

    if (dbl) scaled = $signed({prod, 1'b0});
    else     scaled = $signed({prod[PW-1], prod});
  end

endmodule

// File: rtl/dm16_sat.sv
module dm16_sat #(
  parameter int unsigned IN_W  = 35,
  parameter int unsigned OUT_W = 32
) (
  input  logic signed [IN_W-1:0] val,
  input  logic                   uns,
  output logic [OUT_W-1:0]       q
);

  localparam logic signed [IN_W-1:0] SMAX =
    $signed({{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
  localparam logic signed [IN_W-1:0] SMIN =
    $signed({{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}});
  localparam logic signed [IN_W-1:0] UMAX =
    $signed({{(IN_W-OUT_W){1'b0}}, {OUT_W{1'b1}}});

  always_comb begin
    if (uns) begin
      if (val < 0)          q = '0;
      else if (val > UMAX)  q = '1;
      else                  q = val[OUT_W-1:0];
    end else begin
      if (val > SMAX)       q = SMAX[OUT_W-1:0];
      else if (val < SMIN)  q = SMIN[OUT_W-1:0];
      else                  q = val[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/dual_mul16_sat.sv
module dual_mul16_sat
  import dm16_pkg::*;
#(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [OP_W-1:0]     opa,
  input  logic [OP_W-1:0]     opb,
  input  logic [IDX_W-1:0]    dst_idx,
  input  logic                wide,
  input  logic                hi_half,
  input  logic [1:0]          mode,
  input  logic                mixed,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [1:0]          wr_mask,
  output logic [2*OP_W-1:0]   wr_data,
  output logic                err
);

  localparam int unsigned RES_W = 2 * OP_W;
  localparam int unsigned VW    = 2 * (OP_W + 1) + 1;
  localparam int unsigned RW    = VW + 1;
  localparam int unsigned FW    = RW - OP_W;

  logic       lane, illegal;
  logic [1:0] mask;

  dm16_lane_route #(.IDX_W(IDX_W)) u_route (
    .dst_idx (dst_idx),
    .wide    (wide),
    .hi_half (hi_half),
    .mixed   (mixed),
    .lane    (lane),
    .mask    (mask),
    .illegal (illegal)
  );

  logic signed [VW-1:0] lane_val  [LANE_COUNT];
  logic                 lane_uns  [LANE_COUNT];
  logic                 lane_frac [LANE_COUNT];

  for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
    dm16_mult_core #(.OP_W(OP_W), .LANE(g)) u_core (
      .opa          (opa),
      .opb          (opb),
      .mode         (mul_mode_e'(mode)),
      .mixed        (mixed),
      .scaled       (lane_val[g]),
      .res_unsigned (lane_uns[g]),
      .frac_round   (lane_frac[g])
    );
  end

  logic signed [VW-1:0] sel_val;
  logic                 sel_uns, sel_frac;
  logic signed [RW-1:0] rounded;
  logic signed [FW-1:0] upper;

  always_comb begin
    sel_val  = lane_val[lane];
    sel_uns  = lane_uns[lane];
    sel_frac = lane_frac[lane];
    rounded  = RW'(sel_val) + $signed(RW'(1) <<< (OP_W - 1));
    upper    = FW'(rounded >>> OP_W);
  end

  logic [RES_W-1:0] q_wide;
  logic [OP_W-1:0]  q_frac16, q_int16, q_half;

  dm16_sat #(.IN_W(VW), .OUT_W(RES_W)) u_sat_wide (
    .val (sel_val), .uns (sel_uns), .q (q_wide)
  );
  dm16_sat #(.IN_W(FW), .OUT_W(OP_W)) u_sat_frac (
    .val (upper), .uns (sel_uns), .q (q_frac16)
  );
  dm16_sat #(.IN_W(VW), .OUT_W(OP_W)) u_sat_int (
    .val (sel_val), .uns (sel_uns), .q (q_int16)
  );

  logic [RES_W-1:0] data_next;

  always_comb begin
    q_half = sel_frac ? q_frac16 : q_int16;
    if (wide)      data_next = q_wide;
    else if (lane) data_next = {q_half, {OP_W{1'b0}}};
    else           data_next = {{OP_W{1'b0}}, q_half};
  end

  logic do_write;
  assign do_write = in_valid && !illegal;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_mask <= '0;
      wr_data <= '0;
      err     <= 1'b0;
    end else begin
      wr_en   <= do_write;
      wr_idx  <= do_write ? dst_idx : '0;
      wr_mask <= do_write ? mask : 2'b00;
      wr_data <= do_write ? data_next : '0;
      err     <= in_valid && illegal;
    end
  end

endmodule

// File: rtl/dm16_checker.sv
module dm16_checker #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned IDX_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   opa,
  input logic [OP_W-1:0]   opb,
  input logic [IDX_W-1:0]  dst_idx,
  input logic              wide,
  input logic              hi_half,
  input logic [1:0]        mode,
  input logic              mixed,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [1:0]        wr_mask,
  input logic [2*OP_W-1:0] wr_data,
  input logic              err
);

  AST_IDX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_idx == $past(dst_idx)); // R1
  AST_WIDE_FULL_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wide)) |-> wr_mask == 2'b11); // R1
  AST_HALF_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !$past(wide)) |-> wr_mask == ($past(hi_half) ? 2'b10 : 2'b01)); // R2
  AST_LOW_HALF_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_mask == 2'b01) |-> wr_data[2*OP_W-1:OP_W] == '0); // R2
  AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && err)); // R3
  AST_ERR_NEEDS_MIXED: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(mixed) && $past(in_valid))); // R3
  AST_MIXED_UPPER_LANE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(mixed)) |-> ($past(wide) ? $past(dst_idx[0]) : $past(hi_half))); // R3
  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(in_valid)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> (!wr_en && !err && wr_mask == 2'b00 && wr_data == '0)); // R10

endmodule

bind dual_mul16_sat dm16_checker #(.OP_W(OP_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/dual_mul16_sat_test.sv
`timescale 1ns/1ps
module dual_mul16_sat_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic [2:0]  dst_idx = '0;
  logic        wide = 1'b0, hi_half = 1'b0, mixed = 1'b0;
  logic [1:0]  mode = '0;
  logic        wr_en, err;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_mask;
  logic [31:0] wr_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dual_mul16_sat uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
    .dst_idx(dst_idx), .wide(wide), .hi_half(hi_half), .mode(mode),
    .mixed(mixed), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
    .wr_data(wr_data), .err(err)
  );

  // {opa, opb, idx, wide, hi, mode, mixed, exp_en, exp_mask, exp_data, exp_err}
  localparam int NV = 27;
  localparam logic [75:0] VEC [NV] = '{
    {16'h4000,16'h4000,3'd0,1'b1,1'b0,2'd0,1'b0, 1'b1,2'b11,32'h20000000,1'b0}, // R1 R4 even
    {16'h8000,16'h8000,3'd1,1'b1,1'b0,2'd0,1'b0, 1'b1,2'b11,32'h7FFFFFFF,1'b0}, // R1 R4 sat
    {16'h4000,16'h4000,3'd0,1'b1,1'b1,2'd0,1'b0, 1'b1,2'b11,32'h20000000,1'b0}, // R1 hi ignored
    {16'h4000,16'h4000,3'd2,1'b0,1'b0,2'd0,1'b0, 1'b1,2'b01,32'h00002000,1'b0}, // R2 low
    {16'h8000,16'h8000,3'd3,1'b0,1'b1,2'd0,1'b0, 1'b1,2'b10,32'h7FFF0000,1'b0}, // R2 R4 high sat
    {16'h0001,16'h4000,3'd2,1'b0,1'b0,2'd0,1'b0, 1'b1,2'b01,32'h00000001,1'b0}, // R9 tie up
    {16'h0001,16'h3FFF,3'd2,1'b0,1'b0,2'd0,1'b0, 1'b1,2'b01,32'h00000000,1'b0}, // R9 below half
    {16'h8000,16'h4000,3'd4,1'b1,1'b0,2'd0,1'b0, 1'b1,2'b11,32'hC0000000,1'b0}, // R4 negative
    {16'h8000,16'h4000,3'd4,1'b0,1'b0,2'd0,1'b0, 1'b1,2'b01,32'h0000C000,1'b0}, // R9 negative
    {16'h7FFF,16'h7FFF,3'd5,1'b1,1'b0,2'd2,1'b0, 1'b1,2'b11,32'h3FFF0001,1'b0}, // R5
    {16'h0100,16'h0100,3'd6,1'b0,1'b0,2'd2,1'b0, 1'b1,2'b01,32'h00007FFF,1'b0}, // R5 R9 pos sat
    {16'hFF00,16'h0100,3'd6,1'b0,1'b0,2'd2,1'b0, 1'b1,2'b01,32'h00008000,1'b0}, // R5 neg sat
    {16'hFFFD,16'h0005,3'd6,1'b0,1'b0,2'd2,1'b0, 1'b1,2'b01,32'h0000FFF1,1'b0}, // R5 small
    {16'h8000,16'h8000,3'd6,1'b1,1'b0,2'd3,1'b0, 1'b1,2'b11,32'h7FFFFFFF,1'b0}, // R6 sat
    {16'h0003,16'hFFFB,3'd7,1'b0,1'b1,2'd3,1'b0, 1'b1,2'b10,32'hFFE20000,1'b0}, // R6 high
    {16'h0003,16'h0005,3'd0,1'b1,1'b0,2'd3,1'b0, 1'b1,2'b11,32'h0000001E,1'b0}, // R6 small
    {16'hFFFF,16'hFFFF,3'd7,1'b1,1'b0,2'd1,1'b0, 1'b1,2'b11,32'hFFFE0001,1'b0}, // R7
    {16'hFFFF,16'hFFFF,3'd1,1'b0,1'b1,2'd1,1'b0, 1'b1,2'b10,32'hFFFE0000,1'b0}, // R7 R9
    {16'h8000,16'h0002,3'd1,1'b0,1'b0,2'd1,1'b0, 1'b1,2'b01,32'h00000001,1'b0}, // R7 R9
    {16'hFFFF,16'hFFFF,3'd1,1'b1,1'b0,2'd0,1'b1, 1'b1,2'b11,32'hFFFE0002,1'b0}, // R8 frac
    {16'h0002,16'hFFFF,3'd3,1'b0,1'b1,2'd2,1'b1, 1'b1,2'b10,32'h7FFF0000,1'b0}, // R8 int sat
    {16'hFFFF,16'h8000,3'd3,1'b0,1'b1,2'd2,1'b1, 1'b1,2'b10,32'h80000000,1'b0}, // R8 int min
    {16'h8000,16'hFFFF,3'd3,1'b1,1'b0,2'd3,1'b1, 1'b1,2'b11,32'h80000000,1'b0}, // R8 R6
    {16'h8000,16'h0002,3'd5,1'b1,1'b0,2'd1,1'b1, 1'b1,2'b11,32'hFFFF0000,1'b0}, // R8 R7
    {16'h4000,16'h4000,3'd2,1'b1,1'b0,2'd0,1'b1, 1'b0,2'b00,32'h00000000,1'b1}, // R3 even
    {16'h4000,16'h4000,3'd0,1'b1,1'b1,2'd0,1'b1, 1'b0,2'b00,32'h00000000,1'b1}, // R3 hi ignored
    {16'h4000,16'h4000,3'd5,1'b0,1'b0,2'd2,1'b1, 1'b0,2'b00,32'h00000000,1'b1}  // R3 low half
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic e_en, input logic [1:0] e_mask,
                           input logic [2:0] e_idx, input logic [31:0] e_data,
                           input logic e_err);
    check(wr_en === e_en,     {req, " wr_en"},   32'(wr_en),   32'(e_en));
    check(wr_mask === e_mask, {req, " wr_mask"}, 32'(wr_mask), 32'(e_mask));
    check(wr_idx === e_idx,   {req, " wr_idx"},  32'(wr_idx),  32'(e_idx));
    check(wr_data === e_data, {req, " wr_data"}, wr_data,      e_data);
    check(err === e_err,      {req, " err"},     32'(err),     32'(e_err));
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [2:0] idx,
                       input logic w, input logic h, input logic [1:0] m, input logic x,
                       input logic v);
    opa = a; opb = b; dst_idx = idx; wide = w; hi_half = h; mode = m; mixed = x;
    in_valid = v;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R11 reset", 1'b0, 2'b00, 3'd0, 32'h0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VEC[i];
      @(negedge clk);
      drive(v[75:60], v[59:44], v[43:41], v[40], v[39], v[38:37], v[36], 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      check_all($sformatf("vector %0d", i), v[35], v[34:33],
                v[35] ? v[43:41] : 3'd0, v[32:1], v[0]);
    end

    // R10: idle cycle with live operands writes nothing
    @(negedge clk);
    drive(16'h7FFF, 16'h7FFF, 3'd5, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0);
    @(negedge clk);
    check_all("R10 idle", 1'b0, 2'b00, 3'd0, 32'h0, 1'b0);
    drive(16'h4000, 16'h4000, 3'd2, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0);
    @(negedge clk);
    check_all("R10 idle illegal", 1'b0, 2'b00, 3'd0, 32'h0, 1'b0);

    // R10: back-to-back requests, one result per cycle
    drive(16'h0003, 16'h0005, 3'd4, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1);
    @(negedge clk);
    check_all("R10 first", 1'b1, 2'b11, 3'd4, 32'h0000000F, 1'b0);
    drive(16'h0002, 16'h0007, 3'd7, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1);
    @(negedge clk);
    check_all("R10 second", 1'b1, 2'b10, 3'd7, 32'h000E0000, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    check_all("R10 drain", 1'b0, 2'b00, 3'd0, 32'h0, 1'b0);

    // R11: reset in the same cycle as a request
    drive(16'h7FFF, 16'h7FFF, 3'd1, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check_all("R11 reset with request", 1'b0, 2'b00, 3'd0, 32'h0, 1'b0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule